// File: doc/BRIEF.md
# Time-Windowed Stream Gate Policer

This block performs admission control on ingress frames, one stream at a time. Each frame offers a lookup key made of its destination MAC address, its VLAN ID and its VLAN priority code. The key is compared against a small table of programmed streams. A frame that matches a stream is checked against that stream's periodic time window. A frame that arrives while the window is open is sent to the stream's own destination set. A frame that arrives while the window is closed is dropped. A frame that matches nothing passes through untouched and is left to normal forwarding.

Time is kept on a grid of 200 ns slots. An external pulse, `slot_tick`, marks the end of each slot, and an internal slot counter starts at zero after reset. Each stream has a start slot, an open length and a closed length. Its window first opens at the start slot and then repeats with a period equal to the open length plus the closed length. A frame is judged at the slot in which its first byte arrived, which is the cycle in which `frm_valid` is sampled. Every stream keeps one saturating packet counter. This counter counts drops of three kinds: late or early arrival, an empty destination set, and an oversize frame.

When the arriving port is not VLAN-aware, only the MAC part of the key comes from the frame. The VID and priority parts are taken from per-port defaults.

Top module: `stream_gate_policer`

## Requirements
- R1: A frame matches an entry only if the entry is enabled and its MAC, VID and PCP all equal the frame's key.
- R2: When `frm_vlan_aware` is 0, the VID and PCP of the key come from the defaults programmed for `frm_port`, and the frame's own VID and PCP are ignored.
- R3: When more than one entry matches, the entry with the lowest index decides the result, and `res_flow` reports that index.
- R4: An unmatched frame gives `res_action` = 0 (normal forwarding), `res_hit` = 0 and `res_mask` = 0.
- R5: A stream's window is open in slot s exactly when s >= start and (s - start) mod (open + closed) < open. It is closed in every slot before the start slot.
- R6: A matched frame that is admitted gives `res_action` = 1. Its `res_mask` is the redirect mask, with bit CPU_PORT also set when trap is enabled.
- R7: A matched frame that arrives in a closed slot gives `res_action` = 2 (drop) and `res_mask` = 0.
- R8: A matched stream whose redirect mask is zero and whose trap is off drops every frame (action 2).
- R9: A matched frame whose length is greater than the stream's MTU is dropped. A frame whose length equals the MTU is not dropped for its length.
- R10: Each dropped frame adds one to its stream's counter. The counter holds at 2^CNT_W - 1 and does not wrap.
- R11: A `cnt_clr` bit sets that stream's counter to zero. The clear takes priority over a drop in the same cycle and leaves the other streams' counters unchanged.
- R12: After reset `res_valid` is 0 and all counters are 0. `res_valid` rises exactly one cycle after each sampled `frm_valid`, and at no other time.
- R13: `cnt_rd_val` shows the counter selected by `cnt_rd_idx`, one cycle after the index is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | Pulse that ends the current 200 ns slot |
| cfg_we | input | 1 | Write one stream entry |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_valid | input | 1 | Entry enable |
| cfg_mac | input | MAC_W | Key: destination MAC |
| cfg_vid | input | VID_W | Key: VLAN ID |
| cfg_pcp | input | PCP_W | Key: priority code |
| cfg_base | input | TIME_W | Slot in which the window first opens |
| cfg_open | input | DUR_W | Open length in slots |
| cfg_close | input | DUR_W | Closed length in slots |
| cfg_dest | input | N_PORTS | Redirect port mask |
| cfg_trap | input | 1 | Also send to the CPU port |
| cfg_mtu | input | LEN_W | Largest admitted frame length |
| pdef_we | input | 1 | Write one port default |
| pdef_port | input | PORT_W | Port whose default is written |
| pdef_vid | input | VID_W | Default VID |
| pdef_pcp | input | PCP_W | Default PCP |
| frm_valid | input | 1 | Frame descriptor present |
| frm_port | input | PORT_W | Ingress port |
| frm_vlan_aware | input | 1 | Use the frame's VID and PCP |
| frm_mac | input | MAC_W | Destination MAC |
| frm_vid | input | VID_W | Frame VID |
| frm_pcp | input | PCP_W | Frame PCP |
| frm_len | input | LEN_W | Frame length in bytes |
| cnt_clr | input | N_FLOWS | Per-stream counter clear |
| cnt_rd_idx | input | IDX_W | Counter select |
| res_valid | output | 1 | Decision present |
| res_hit | output | 1 | Frame matched a stream |
| res_flow | output | IDX_W | Index of the matched stream |
| res_action | output | 2 | 0 normal, 1 route, 2 drop |
| res_mask | output | N_PORTS | Destination ports for a routed frame |
| cnt_rd_val | output | CNT_W | Selected drop counter |

## Verification
The checker tests the following on every cycle:
- one decision comes out per frame, with a one-cycle delay;
- unmatched and dropped frames carry an empty mask;
- a routed frame never carries an empty mask;
- a counter only holds, steps up by one, stops at its maximum, or returns to zero after a clear.

Some behaviour can only be shown by the bench's slot-by-slot sweep, where expected results come from modulo arithmetic:
- whether a given slot is inside a stream's window;
- which entry wins when several match;
- the port-default key substitution;
- the MTU boundary;
- the exact counter totals.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  typedef enum logic [1:0] {
    ACT_NORMAL = 2'd0,
    ACT_ROUTE  = 2'd1,
    ACT_DROP   = 2'd2
  } sgp_action_e;
endpackage

// File: rtl/sgp_flow_table.sv
// Stream entry storage, port defaults, key compare and lowest-index selection.
module sgp_flow_table #(
  parameter int N_FLOWS = 16,
  parameter int N_PORTS = 8,
  parameter int MAC_W   = 48,
  parameter int VID_W   = 12,
  parameter int PCP_W   = 3,
  parameter int TIME_W  = 24,
  parameter int DUR_W   = 16,
  parameter int LEN_W   = 14,
  localparam int IDX_W  = $clog2(N_FLOWS),
  localparam int PORT_W = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_valid,
  input  logic [MAC_W-1:0]   cfg_mac,
  input  logic [VID_W-1:0]   cfg_vid,
  input  logic [PCP_W-1:0]   cfg_pcp,
  input  logic [TIME_W-1:0]  cfg_base,
  input  logic [DUR_W-1:0]   cfg_open,
  input  logic [DUR_W-1:0]   cfg_close,
  input  logic [N_PORTS-1:0] cfg_dest,
  input  logic               cfg_trap,
  input  logic [LEN_W-1:0]   cfg_mtu,
  input  logic               pdef_we,
  input  logic [PORT_W-1:0]  pdef_port,
  input  logic [VID_W-1:0]   pdef_vid,
  input  logic [PCP_W-1:0]   pdef_pcp,
  input  logic [PORT_W-1:0]  frm_port,
  input  logic               frm_vlan_aware,
  input  logic [MAC_W-1:0]   frm_mac,
  input  logic [VID_W-1:0]   frm_vid,
  input  logic [PCP_W-1:0]   frm_pcp,
  output logic               match_hit,
  output logic [IDX_W-1:0]   match_idx,
  output logic [N_PORTS-1:0] sel_dest,
  output logic               sel_trap,
  output logic [LEN_W-1:0]   sel_mtu,
  output logic [TIME_W-1:0]  base_arr  [N_FLOWS],
  output logic [DUR_W-1:0]   open_arr  [N_FLOWS],
  output logic [DUR_W-1:0]   close_arr [N_FLOWS],
  output logic [N_FLOWS-1:0] restart
);
  logic               ent_valid [N_FLOWS];
  logic [MAC_W-1:0]   ent_mac   [N_FLOWS];
  logic [VID_W-1:0]   ent_vid   [N_FLOWS];
  logic [PCP_W-1:0]   ent_pcp   [N_FLOWS];
  logic [N_PORTS-1:0] ent_dest  [N_FLOWS];
  logic               ent_trap  [N_FLOWS];
  logic [LEN_W-1:0]   ent_mtu   [N_FLOWS];
  logic [VID_W-1:0]   dflt_vid  [N_PORTS];
  logic [PCP_W-1:0]   dflt_pcp  [N_PORTS];

  logic [VID_W-1:0]   key_vid;
  logic [PCP_W-1:0]   key_pcp;
  logic [N_FLOWS-1:0] match_vec;

  genvar g;
  generate
    for (g = 0; g < N_FLOWS; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst) begin
          ent_valid[g] <= 1'b0;
          ent_mac[g]   <= '0;
          ent_vid[g]   <= '0;
          ent_pcp[g]   <= '0;
          ent_dest[g]  <= '0;
          ent_trap[g]  <= 1'b0;
          ent_mtu[g]   <= '0;
          base_arr[g]  <= '0;
          open_arr[g]  <= '0;
          close_arr[g] <= '0;
        end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
          ent_valid[g] <= cfg_valid;
          ent_mac[g]   <= cfg_mac;
          ent_vid[g]   <= cfg_vid;
          ent_pcp[g]   <= cfg_pcp;
          ent_dest[g]  <= cfg_dest;
          ent_trap[g]  <= cfg_trap;
          ent_mtu[g]   <= cfg_mtu;
          base_arr[g]  <= cfg_base;
          open_arr[g]  <= cfg_open;
          close_arr[g] <= cfg_close;
        end
      end
      assign restart[g]   = cfg_we && cfg_idx == IDX_W'(g);
      assign match_vec[g] = ent_valid[g] && ent_mac[g] == frm_mac &&
                            ent_vid[g] == key_vid && ent_pcp[g] == key_pcp;
    end

    for (g = 0; g < N_PORTS; g++) begin : g_pdef
      always_ff @(posedge clk) begin
        if (rst) begin
          dflt_vid[g] <= '0;
          dflt_pcp[g] <= '0;
        end else if (pdef_we && pdef_port == PORT_W'(g)) begin
          dflt_vid[g] <= pdef_vid;
          dflt_pcp[g] <= pdef_pcp;
        end
      end
    end
  endgenerate

  assign key_vid = frm_vlan_aware ? frm_vid : dflt_vid[frm_port];
  assign key_pcp = frm_vlan_aware ? frm_pcp : dflt_pcp[frm_port];

  always_comb begin
    match_hit = 1'b0;
    match_idx = '0;
    for (int i = N_FLOWS - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        match_hit = 1'b1;
        match_idx = IDX_W'(i);
      end
    end
  end

  assign sel_dest = ent_dest[match_idx];
  assign sel_trap = ent_trap[match_idx];
  assign sel_mtu  = ent_mtu[match_idx];
endmodule

// File: rtl/sgp_gate_timer.sv
// Per-stream window phase tracker on the slot grid (no divider needed).
module sgp_gate_timer #(
  parameter int TIME_W = 24,
  parameter int DUR_W  = 16,
  localparam int PH_W  = DUR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_tick,
  input  logic [TIME_W-1:0] slot_now,
  input  logic              restart,
  input  logic [TIME_W-1:0] base,
  input  logic [DUR_W-1:0]  open_len,
  input  logic [DUR_W-1:0]  close_len,
  output logic              gate_open
);
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] period;
  logic [PH_W-1:0] phase_inc;
  logic            started;

  assign period    = PH_W'(open_len) + PH_W'(close_len);
  assign phase_inc = phase + 1'b1;
  assign started   = slot_now >= base;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase <= '0;
    end else if (slot_tick && started) begin
      phase <= (phase_inc >= period) ? '0 : phase_inc;
    end
  end

  assign gate_open = started && (phase < PH_W'(open_len));
endmodule

// File: rtl/sgp_drop_counters.sv
// Saturating per-stream drop counters with per-stream clear and a read port.
module sgp_drop_counters #(
  parameter int N_FLOWS = 16,
  parameter int CNT_W   = 8,
  localparam int IDX_W  = $clog2(N_FLOWS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          inc_valid,
  input  logic [IDX_W-1:0]              inc_idx,
  input  logic [N_FLOWS-1:0]            clr,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [CNT_W-1:0]              rd_val,
  output logic [N_FLOWS-1:0][CNT_W-1:0] cnt_all
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  genvar g;
  generate
    for (g = 0; g < N_FLOWS; g++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst || clr[g]) begin
          cnt_all[g] <= '0;
        end else if (inc_valid && inc_idx == IDX_W'(g) && cnt_all[g] != CNT_MAX) begin
          cnt_all[g] <= cnt_all[g] + 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rd_val <= '0;
    else     rd_val <= cnt_all[rd_idx];
  end
endmodule

// File: rtl/stream_gate_policer.sv
module stream_gate_policer #(
  parameter int N_FLOWS  = 16,
  parameter int N_PORTS  = 8,
  parameter int CPU_PORT = 7,
  parameter int MAC_W    = 48,
  parameter int VID_W    = 12,
  parameter int PCP_W    = 3,
  parameter int TIME_W   = 24,
  parameter int DUR_W    = 16,
  parameter int LEN_W    = 14,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(N_FLOWS),
  localparam int PORT_W  = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slot_tick,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_valid,
  input  logic [MAC_W-1:0]   cfg_mac,
  input  logic [VID_W-1:0]   cfg_vid,
  input  logic [PCP_W-1:0]   cfg_pcp,
  input  logic [TIME_W-1:0]  cfg_base,
  input  logic [DUR_W-1:0]   cfg_open,
  input  logic [DUR_W-1:0]   cfg_close,
  input  logic [N_PORTS-1:0] cfg_dest,
  input  logic               cfg_trap,
  input  logic [LEN_W-1:0]   cfg_mtu,
  input  logic               pdef_we,
  input  logic [PORT_W-1:0]  pdef_port,
  input  logic [VID_W-1:0]   pdef_vid,
  input  logic [PCP_W-1:0]   pdef_pcp,
  input  logic               frm_valid,
  input  logic [PORT_W-1:0]  frm_port,
  input  logic               frm_vlan_aware,
  input  logic [MAC_W-1:0]   frm_mac,
  input  logic [VID_W-1:0]   frm_vid,
  input  logic [PCP_W-1:0]   frm_pcp,
  input  logic [LEN_W-1:0]   frm_len,
  input  logic [N_FLOWS-1:0] cnt_clr,
  input  logic [IDX_W-1:0]   cnt_rd_idx,
  output logic               res_valid,
  output logic               res_hit,
  output logic [IDX_W-1:0]   res_flow,
  output logic [1:0]         res_action,
  output logic [N_PORTS-1:0] res_mask,
  output logic [CNT_W-1:0]   cnt_rd_val
);
  import sgp_pkg::*;

  logic [TIME_W-1:0]  slot_now;
  logic               match_hit;
  logic [IDX_W-1:0]   match_idx;
  logic [N_PORTS-1:0] sel_dest;
  logic               sel_trap;
  logic [LEN_W-1:0]   sel_mtu;
  logic [TIME_W-1:0]  base_arr  [N_FLOWS];
  logic [DUR_W-1:0]   open_arr  [N_FLOWS];
  logic [DUR_W-1:0]   close_arr [N_FLOWS];
  logic [N_FLOWS-1:0] restart;
  logic [N_FLOWS-1:0] gate_vec;
  logic [N_PORTS-1:0] trap_bit;
  logic [N_PORTS-1:0] full_mask;
  logic               drop;
  sgp_action_e        action;
  logic [N_FLOWS-1:0][CNT_W-1:0] cnt_all;

  always_ff @(posedge clk) begin
    if (rst)            slot_now <= '0;
    else if (slot_tick) slot_now <= slot_now + 1'b1;
  end

  sgp_flow_table #(
    .N_FLOWS(N_FLOWS), .N_PORTS(N_PORTS), .MAC_W(MAC_W), .VID_W(VID_W),
    .PCP_W(PCP_W), .TIME_W(TIME_W), .DUR_W(DUR_W), .LEN_W(LEN_W)
  ) table_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_mac(cfg_mac), .cfg_vid(cfg_vid), .cfg_pcp(cfg_pcp),
    .cfg_base(cfg_base), .cfg_open(cfg_open), .cfg_close(cfg_close),
    .cfg_dest(cfg_dest), .cfg_trap(cfg_trap), .cfg_mtu(cfg_mtu),
    .pdef_we(pdef_we), .pdef_port(pdef_port), .pdef_vid(pdef_vid), .pdef_pcp(pdef_pcp),
    .frm_port(frm_port), .frm_vlan_aware(frm_vlan_aware),
    .frm_mac(frm_mac), .frm_vid(frm_vid), .frm_pcp(frm_pcp),
    .match_hit(match_hit), .match_idx(match_idx),
    .sel_dest(sel_dest), .sel_trap(sel_trap), .sel_mtu(sel_mtu),
    .base_arr(base_arr), .open_arr(open_arr), .close_arr(close_arr),
    .restart(restart)
  );

  genvar g;
  generate
    for (g = 0; g < N_FLOWS; g++) begin : g_gate
      sgp_gate_timer #(.TIME_W(TIME_W), .DUR_W(DUR_W)) gate_i (
        .clk(clk), .rst(rst), .slot_tick(slot_tick), .slot_now(slot_now),
        .restart(restart[g]), .base(base_arr[g]),
        .open_len(open_arr[g]), .close_len(close_arr[g]),
        .gate_open(gate_vec[g])
      );
    end
  endgenerate

  always_comb begin
    trap_bit           = '0;
    trap_bit[CPU_PORT] = sel_trap;
  end
  assign full_mask = sel_dest | trap_bit;
  assign drop = match_hit &&
                (!gate_vec[match_idx] || full_mask == '0 || frm_len > sel_mtu);

  always_comb begin
    if (!match_hit) action = ACT_NORMAL;
    else if (drop)  action = ACT_DROP;
    else            action = ACT_ROUTE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_flow   <= '0;
      res_action <= ACT_NORMAL;
      res_mask   <= '0;
    end else begin
      res_valid  <= frm_valid;
      res_hit    <= frm_valid && match_hit;
      res_flow   <= match_hit ? match_idx : '0;
      res_action <= frm_valid ? action : ACT_NORMAL;
      res_mask   <= (frm_valid && action == ACT_ROUTE) ? full_mask : '0;
    end
  end

  sgp_drop_counters #(.N_FLOWS(N_FLOWS), .CNT_W(CNT_W)) counters_i (
    .clk(clk), .rst(rst),
    .inc_valid(frm_valid && drop), .inc_idx(match_idx),
    .clr(cnt_clr), .rd_idx(cnt_rd_idx), .rd_val(cnt_rd_val),
    .cnt_all(cnt_all)
  );
endmodule

// File: rtl/sgp_checker.sv
module sgp_checker #(
  parameter int N_FLOWS = 16,
  parameter int N_PORTS = 8,
  parameter int CNT_W   = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          frm_valid,
  input logic                          res_valid,
  input logic                          res_hit,
  input logic [1:0]                    res_action,
  input logic [N_PORTS-1:0]            res_mask,
  input logic [N_FLOWS-1:0]            cnt_clr,
  input logic [N_FLOWS-1:0][CNT_W-1:0] cnt_all
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r12_one_result: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> res_valid);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |=> !res_valid);
  a_r4_normal_empty: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_action == 2'd0) |-> (res_mask == '0 && !res_hit));
  a_r7_drop_empty: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_action == 2'd2) |-> (res_mask == '0 && res_hit));
  a_r6_route_nonempty: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_action == 2'd1) |-> (res_mask != '0 && res_hit));

  genvar g;
  generate
    for (g = 0; g < N_FLOWS; g++) begin : g_chk
      a_r10_step_one: assert property (@(posedge clk) disable iff (rst)
        (!$past(cnt_clr[g]) && cnt_all[g] != $past(cnt_all[g]))
          |-> cnt_all[g] == $past(cnt_all[g]) + 1'b1);
      a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
        (!$past(cnt_clr[g]) && $past(cnt_all[g]) == CNT_MAX) |-> cnt_all[g] == CNT_MAX);
      a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
        $past(cnt_clr[g]) |-> cnt_all[g] == '0);
    end
  endgenerate
endmodule

bind stream_gate_policer sgp_checker #(
  .N_FLOWS(N_FLOWS), .N_PORTS(N_PORTS), .CNT_W(CNT_W)
) checker_i (
  .clk(clk), .rst(rst), .frm_valid(frm_valid), .res_valid(res_valid),
  .res_hit(res_hit), .res_action(res_action), .res_mask(res_mask),
  .cnt_clr(cnt_clr), .cnt_all(cnt_all)
);

// File: tb/stream_gate_policer_tb.sv
`timescale 1ns/1ps
module stream_gate_policer_tb_top;
  localparam int NF = 16, NP = 8, CPU = 7, CNT_MAX = 255;
  localparam time TCK = 20ns;

  logic clk = 1'b0, rst = 1'b1, slot_tick = 1'b0;
  logic cfg_we = 0; logic [3:0] cfg_idx = '0; logic cfg_valid = 0;
  logic [47:0] cfg_mac = '0; logic [11:0] cfg_vid = '0; logic [2:0] cfg_pcp = '0;
  logic [23:0] cfg_base = '0; logic [15:0] cfg_open = '0, cfg_close = '0;
  logic [7:0] cfg_dest = '0; logic cfg_trap = 0; logic [13:0] cfg_mtu = '0;
  logic pdef_we = 0; logic [2:0] pdef_port = '0; logic [11:0] pdef_vid = '0; logic [2:0] pdef_pcp = '0;
  logic frm_valid = 0; logic [2:0] frm_port = '0; logic frm_vlan_aware = 0;
  logic [47:0] frm_mac = '0; logic [11:0] frm_vid = '0; logic [2:0] frm_pcp = '0;
  logic [13:0] frm_len = '0; logic [15:0] cnt_clr = '0; logic [3:0] cnt_rd_idx = '0;
  logic res_valid, res_hit; logic [3:0] res_flow; logic [1:0] res_action;
  logic [7:0] res_mask, cnt_rd_val;

  always #(TCK/2) clk = ~clk;

  stream_gate_policer dut_i (.*);

  int checks = 0, fails = 0, cur_slot = 0;
  logic [47:0] m_mac [NF]; int m_vid [NF], m_pcp [NF], m_base [NF], m_open [NF], m_close [NF];
  int m_dest [NF], m_trap [NF], m_mtu [NF], m_valid [NF], m_cnt [NF];
  int pd_vid [NP], pd_pcp [NP];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic bit win(input int i, input int s);
    int per = m_open[i] + m_close[i];
    if (s < m_base[i] || per == 0) return 1'b0;
    return ((s - m_base[i]) % per) < m_open[i];
  endfunction

  task automatic tick();
    @(negedge clk) slot_tick = 1;
    @(negedge clk) slot_tick = 0;
    cur_slot++;
  endtask

  task automatic send(input int port, input bit aware, input logic [47:0] mac,
                      input int vid, input int pcp, input int len, input int clr_bit);
    int kv, kp, hit, emask, eact; string tag;
    kv = aware ? vid : pd_vid[port];
    kp = aware ? pcp : pd_pcp[port];
    hit = -1;
    for (int i = NF - 1; i >= 0; i--)
      if (m_valid[i] != 0 && m_mac[i] == mac && m_vid[i] == kv && m_pcp[i] == kp) hit = i;
    emask = 0; eact = 0; tag = "R4_R1";
    if (hit >= 0) begin
      emask = m_dest[hit] | (m_trap[hit] << CPU);
      if (emask == 0)               begin eact = 2; tag = "R8"; end
      else if (len > m_mtu[hit])    begin eact = 2; tag = "R9"; end
      else if (!win(hit, cur_slot)) begin eact = 2; tag = "R7_R5"; end
      else                          begin eact = 1; tag = "R6_R5"; end
      if (eact == 2) begin
        emask = 0;
        if (clr_bit != hit && m_cnt[hit] < CNT_MAX) m_cnt[hit]++;
      end
      if (!aware) tag = {tag, "_R2"};
      if (hit == 3) tag = {tag, "_R3"};
    end
    if (clr_bit >= 0) m_cnt[clr_bit] = 0;
    @(negedge clk);
    frm_valid = 1; frm_port = 3'(port); frm_vlan_aware = aware; frm_mac = mac;
    frm_vid = 12'(vid); frm_pcp = 3'(pcp); frm_len = 14'(len);
    cnt_clr = (clr_bit >= 0) ? 16'(1 << clr_bit) : '0;
    @(negedge clk);
    frm_valid = 0; cnt_clr = '0;
    chk(res_valid == 1'b1, "R12 res_valid", res_valid, 1);
    chk(res_action == 2'(eact), tag, res_action, eact);
    chk(res_mask == 8'(emask), {tag, " mask"}, res_mask, emask);
    chk(res_hit == (hit >= 0), {tag, " hit"}, res_hit, hit >= 0);
    if (hit >= 0) chk(res_flow == 4'(hit), {tag, " flow"}, res_flow, hit);
  endtask

  task automatic rd(input int i, input string rq);
    @(negedge clk) cnt_rd_idx = 4'(i);
    @(negedge clk);
    chk(cnt_rd_val == 8'(m_cnt[i]), rq, cnt_rd_val, m_cnt[i]);
  endtask

  initial begin : watchdog
    #(TCK * 200000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NF; i++) begin
      m_mac[i] = 48'h02AB_0000_0000 + 48'(i * 3);
      m_vid[i] = i + 1; m_pcp[i] = i % 8; m_base[i] = 2 + i;
      m_open[i] = 1 + (i % 3); m_close[i] = 2 + (i % 4);
      m_dest[i] = (i * 37 + 5) & 8'h7F; m_trap[i] = i % 2; m_mtu[i] = 100 + i * 8;
      m_valid[i] = 1; m_cnt[i] = 0;
    end
    m_dest[5] = 0; m_trap[5] = 0;            // R8: empty routing action
    m_dest[6] = 0; m_trap[6] = 1;            // trap only
    m_mac[9] = m_mac[3]; m_vid[9] = m_vid[3]; m_pcp[9] = m_pcp[3]; // R3: duplicate key
    m_valid[15] = 0;                         // R1: disabled entry
    for (int p = 0; p < NP; p++) begin pd_vid[p] = 0; pd_pcp[p] = 0; end
    pd_vid[2] = m_vid[4]; pd_pcp[2] = m_pcp[4];

    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(res_valid == 1'b0, "R12 reset res_valid", res_valid, 0);
    for (int i = 0; i < NF; i++) rd(i, "R12_R13 reset counter");

    for (int i = 0; i < NF; i++) begin
      @(negedge clk);
      cfg_we = 1; cfg_idx = 4'(i); cfg_valid = m_valid[i][0]; cfg_mac = m_mac[i];
      cfg_vid = 12'(m_vid[i]); cfg_pcp = 3'(m_pcp[i]); cfg_base = 24'(m_base[i]);
      cfg_open = 16'(m_open[i]); cfg_close = 16'(m_close[i]); cfg_dest = 8'(m_dest[i]);
      cfg_trap = m_trap[i][0]; cfg_mtu = 14'(m_mtu[i]);
    end
    @(negedge clk) cfg_we = 0; pdef_we = 1; pdef_port = 3'd2;
    pdef_vid = 12'(pd_vid[2]); pdef_pcp = 3'(pd_pcp[2]);
    @(negedge clk) pdef_we = 0;

    // Slot sweep: every stream in every slot, plus key-substitution and MTU edges.
    for (int s = 0; s < 36; s++) begin
      for (int i = 0; i < NF; i++) send(1, 1, m_mac[i], m_vid[i], m_pcp[i], 64, -1);
      send(1, 1, 48'hFFFF_FFFF_FFFF, 1, 0, 64, -1);              // R4
      send(1, 1, m_mac[0], m_vid[0] + 1, m_pcp[0], 64, -1);      // R1 VID mismatch
      send(2, 0, m_mac[4], 12'hABC, 5, 64, -1);                  // R2 defaults used
      send(1, 0, m_mac[4], m_vid[4], m_pcp[4], 64, -1);          // R2 frame VID ignored
      send(1, 1, m_mac[0], m_vid[0], m_pcp[0], m_mtu[0], -1);    // R9 boundary
      send(1, 1, m_mac[0], m_vid[0], m_pcp[0], m_mtu[0] + 1, -1);
      tick();
    end
    for (int i = 0; i < NF; i++) rd(i, "R10 sweep total");

    for (int k = 0; k < 300; k++) send(1, 1, m_mac[5], m_vid[5], m_pcp[5], 64, -1);
    rd(5, "R10 saturation");
    @(negedge clk) cnt_clr = 16'h0020; m_cnt[5] = 0;
    @(negedge clk) cnt_clr = '0;
    rd(5, "R11 clear");
    rd(6, "R11 neighbour kept");
    send(1, 1, m_mac[5], m_vid[5], m_pcp[5], 64, 5);             // R11 clear beats drop
    rd(5, "R11 clear with drop");
    send(1, 1, m_mac[5], m_vid[5], m_pcp[5], 64, -1);
    rd(5, "R10 count after clear");
    @(negedge clk);
    chk(res_valid == 1'b0, "R12 idle res_valid", res_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule